// File: doc/BRIEF.md
# Requester ID Partition Classifier

This block sorts inbound PCI transactions into isolation partitions by their 16-bit requester ID. The ID is read as bus number in bits 15:8, device in bits 7:3 and function in bits 2:0. A small table of programmable rules decides the partition. Each rule compares a chosen number of leading bus-number bits and, if enabled, the full device/function byte as well. The block returns a hit flag and the partition number of the first rule that matches.

The same matching logic also guards message-signalled interrupt writes. Every interrupt source holds a partition tag. An MSI write is authorized only when its sender classifies to a partition and that partition equals the tag of the targeted source. Rejected writes increase a sticky, saturating counter. Rules and tags are loaded through one register write port.

Top module: `rid_pe_classifier`

## Requirements
- R1: After reset every rule is invalid, every source tag is 0, and `cls_valid`, `cls_hit`, `cls_pe`, `msi_accept`, `msi_reject` and `rej_count` are all zero.
- R2: A valid rule matches a requester ID when the leading `plen` bits of its bus field equal the same bits of ID bits 15:8.
- R3: A `plen` of 0 matches every bus number. A `plen` of 8 or more (up to 15) requires the whole bus byte to be equal.
- R4: When a rule's devfn-enable bit is set, ID bits 7:0 must also equal the rule's devfn byte. When it is clear, those bits are ignored.
- R5: When several rules match, the partition number comes from the rule with the lowest index.
- R6: A request sampled with `req_valid` high yields `cls_valid` high one cycle later, with `cls_hit` and `cls_pe`. On a miss `cls_hit` is 0 and `cls_pe` is 0. Without a request `cls_valid` is 0.
- R7: A configuration write takes effect for requests from the next cycle. A request in the same cycle as the write sees the old contents.
- R8: A rule whose valid bit is 0 never matches.
- R9: An MSI write (`msi_valid`) whose sender hits and whose partition equals the tag of `msi_src` raises `msi_accept` for one cycle, one cycle later.
- R10: An MSI write whose sender misses, or whose partition differs from the source tag, raises `msi_reject` for one cycle, one cycle later. `msi_accept` and `msi_reject` are never high together.
- R11: `rej_count` goes up by one on each reject, holds at its maximum 2^REJ_W-1, and is cleared only by reset.
- R12: With `cfg_we` high, `cfg_sel`=0 writes rule `cfg_addr` and `cfg_sel`=1 writes the tag of source `cfg_addr`. An address beyond the table is ignored. The `cfg_wdata` layout is: devfn in bits 7:0, bus in 15:8, plen in 19:16, devfn-enable in bit 20, valid in bit 21, and partition in bits 22 upward. A tag write uses only the partition field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects a rule, 1 selects a source tag |
| cfg_addr | input | CFG_AW (8) | Rule or source index |
| cfg_wdata | input | 22+PE_W (29) | Write data, layout per R12 |
| req_valid | input | 1 | Classification request |
| req_rid | input | 16 | Requester ID to classify |
| cls_valid | output | 1 | Registered result valid |
| cls_hit | output | 1 | A rule matched |
| cls_pe | output | PE_W (7) | Partition of the winning rule |
| msi_valid | input | 1 | MSI write presented |
| msi_rid | input | 16 | Requester ID of the MSI sender |
| msi_src | input | clog2(NSRC) (5) | Targeted interrupt source |
| msi_accept | output | 1 | MSI authorized |
| msi_reject | output | 1 | MSI refused |
| rej_count | output | REJ_W (16) | Sticky saturating reject count |

## Verification
The bench keeps the default 16 rules and 7-bit partitions. It narrows the design to 8 interrupt sources and a 3-bit reject counter, so saturation at 7 is reached after a few refused writes and the hold-at-maximum rule can be tested. Directed phases cover overlapping rules, prefix lengths 0, 4, 8 and 12, device/function filtering, and a write that lands in the same cycle as a lookup. A long random phase then mixes rewrites of rules and tags with bus numbers chosen to sit near prefix boundaries.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  localparam int RID_W = 16;

  // One classification rule (partition number is stored beside it).
  typedef struct packed {
    logic       valid;
    logic       devfn_en;
    logic [3:0] plen;
    logic [7:0] bus;
    logic [7:0] devfn;
  } rid_rule_t;

  // Mask of the leading bus bits that a prefix length covers.
  function automatic logic [7:0] bus_mask(input logic [3:0] plen);
    logic [7:0] m;
    m = '0;
    for (int b = 0; b < 8; b++) begin
      if (b < int'(plen)) m[7-b] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic rule_hits(input rid_rule_t r, input logic [RID_W-1:0] rid);
    logic bus_ok, fn_ok;
    bus_ok = (((rid[15:8] ^ r.bus) & bus_mask(r.plen)) == 8'h00);
    fn_ok  = !r.devfn_en || (rid[7:0] == r.devfn);
    return r.valid && bus_ok && fn_ok;
  endfunction

endpackage

// File: rtl/rpc_rule_table.sv
module rpc_rule_table
  import rpc_pkg::*;
#(
  parameter int N    = 16,
  parameter int PE_W = 7,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_idx,
  input  rid_rule_t                 wr_rule,
  input  logic [PE_W-1:0]           wr_pe,
  output rid_rule_t [N-1:0]         rules,
  output logic [N-1:0][PE_W-1:0]    pes
);

  for (genvar i = 0; i < N; i++) begin : g_slot
    wire slot_we = wr_en && (wr_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rules[i] <= '0;
        pes[i]   <= '0;
      end else if (slot_we) begin
        rules[i] <= wr_rule;
        pes[i]   <= wr_pe;
      end
    end
  end

  // R7: a write is visible in the table from the following cycle
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rules[$past(wr_idx)] == $past(wr_rule)) && (pes[$past(wr_idx)] == $past(wr_pe)));

endmodule

// File: rtl/rpc_lookup.sv
module rpc_lookup
  import rpc_pkg::*;
#(
  parameter int N    = 16,
  parameter int PE_W = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [RID_W-1:0]          rid,
  input  rid_rule_t [N-1:0]         rules,
  input  logic [N-1:0][PE_W-1:0]    pes,
  output logic                      hit,
  output logic [PE_W-1:0]           pe
);

  logic [N-1:0] raw_hit;
  logic [N-1:0] winner;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign raw_hit[i] = rule_hits(rules[i], rid);
  end

  // Lowest index wins: scan downwards so the last assignment is the lowest.
  always_comb begin
    winner = '0;
    hit    = 1'b0;
    pe     = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (raw_hit[i]) begin
        winner    = '0;
        winner[i] = 1'b1;
        hit       = 1'b1;
        pe        = pes[i];
      end
    end
  end

  // R5: at most one rule is selected
  a_r5_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winner));
  // R5: any raw match produces a hit
  a_r5_hit_when_any: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hit != '0) |-> hit);

endmodule

// File: rtl/rpc_msi_gate.sv
module rpc_msi_gate #(
  parameter int NSRC  = 32,
  parameter int PE_W  = 7,
  parameter int REJ_W = 16,
  localparam int SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_we,
  input  logic [SW-1:0]    tag_idx,
  input  logic [PE_W-1:0]  tag_pe,
  input  logic             msi_valid,
  input  logic [SW-1:0]    msi_src,
  input  logic             sender_hit,
  input  logic [PE_W-1:0]  sender_pe,
  output logic             msi_accept,
  output logic             msi_reject,
  output logic [REJ_W-1:0] rej_count
);

  localparam logic [REJ_W-1:0] REJ_MAX = '1;

  logic [NSRC-1:0][PE_W-1:0] tags;

  for (genvar s = 0; s < NSRC; s++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              tags[s] <= '0;
      else if (tag_we && tag_idx == SW'(s))    tags[s] <= tag_pe;
    end
  end

  wire authorized = sender_hit && (sender_pe == tags[msi_src]);
  wire grant_now  = msi_valid && authorized;
  wire refuse_now = msi_valid && !authorized;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msi_accept <= 1'b0;
      msi_reject <= 1'b0;
      rej_count  <= '0;
    end else begin
      msi_accept <= grant_now;
      msi_reject <= refuse_now;
      if (refuse_now && rej_count != REJ_MAX) rej_count <= rej_count + 1'b1;
    end
  end

  // R10: verdicts are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(msi_accept && msi_reject));
  // R10: an unclassified sender is always refused
  a_r10_miss_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && !sender_hit) |=> msi_reject);
  // R11: the counter moves only on a reject
  a_r11_moves_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_count != $past(rej_count)) |-> msi_reject);
  // R11: a reject below saturation adds exactly one
  a_r11_step: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_reject && $past(rej_count) != REJ_MAX) |-> (rej_count == $past(rej_count) + 1'b1));

endmodule

// File: rtl/rid_pe_classifier.sv
module rid_pe_classifier
  import rpc_pkg::*;
#(
  parameter int N      = 16,
  parameter int PE_W   = 7,
  parameter int NSRC   = 32,
  parameter int REJ_W  = 16,
  parameter int CFG_AW = 8,
  localparam int CFG_DW = 22 + PE_W,
  localparam int IW     = (N > 1) ? $clog2(N) : 1,
  localparam int SW     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [15:0]       req_rid,
  output logic              cls_valid,
  output logic              cls_hit,
  output logic [PE_W-1:0]   cls_pe,
  input  logic              msi_valid,
  input  logic [15:0]       msi_rid,
  input  logic [SW-1:0]     msi_src,
  output logic              msi_accept,
  output logic              msi_reject,
  output logic [REJ_W-1:0]  rej_count
);

  // Configuration decode
  rid_rule_t       new_rule;
  logic [PE_W-1:0] new_pe;
  assign new_rule.devfn    = cfg_wdata[7:0];
  assign new_rule.bus      = cfg_wdata[15:8];
  assign new_rule.plen     = cfg_wdata[19:16];
  assign new_rule.devfn_en = cfg_wdata[20];
  assign new_rule.valid    = cfg_wdata[21];
  assign new_pe            = cfg_wdata[22 +: PE_W];

  wire rule_we = cfg_we && !cfg_sel && (int'(cfg_addr) < N);
  wire tag_we  = cfg_we &&  cfg_sel && (int'(cfg_addr) < NSRC);

  rid_rule_t [N-1:0]      rules;
  logic [N-1:0][PE_W-1:0] pes;

  rpc_rule_table #(.N(N), .PE_W(PE_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rule_we), .wr_idx(cfg_addr[IW-1:0]),
    .wr_rule(new_rule), .wr_pe(new_pe),
    .rules(rules), .pes(pes)
  );

  // Two identical lookups: one for classification, one for MSI senders
  logic            req_hit, snd_hit;
  logic [PE_W-1:0] req_pe,  snd_pe;

  rpc_lookup #(.N(N), .PE_W(PE_W)) u_req_lookup (
    .clk(clk), .rst_n(rst_n), .rid(req_rid),
    .rules(rules), .pes(pes), .hit(req_hit), .pe(req_pe)
  );

  rpc_lookup #(.N(N), .PE_W(PE_W)) u_msi_lookup (
    .clk(clk), .rst_n(rst_n), .rid(msi_rid),
    .rules(rules), .pes(pes), .hit(snd_hit), .pe(snd_pe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_valid <= 1'b0;
      cls_hit   <= 1'b0;
      cls_pe    <= '0;
    end else begin
      cls_valid <= req_valid;
      cls_hit   <= req_valid && req_hit;
      cls_pe    <= (req_valid && req_hit) ? req_pe : '0;
    end
  end

  rpc_msi_gate #(.NSRC(NSRC), .PE_W(PE_W), .REJ_W(REJ_W)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .tag_we(tag_we), .tag_idx(cfg_addr[SW-1:0]), .tag_pe(new_pe),
    .msi_valid(msi_valid), .msi_src(msi_src),
    .sender_hit(snd_hit), .sender_pe(snd_pe),
    .msi_accept(msi_accept), .msi_reject(msi_reject), .rej_count(rej_count)
  );

  // R6: result valid tracks the request one cycle later
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> cls_valid);
  a_r6_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !cls_valid);
  // R6: a miss reports partition zero
  a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && !cls_hit) |-> (cls_pe == '0));
  // R9: an accept only follows a presented MSI write
  a_r9_accept_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_valid |=> !msi_accept);

endmodule

// File: tb/rid_pe_classifier_test.sv
`timescale 1ns/1ps
module rid_pe_classifier_test;

  localparam int N = 16, PE_W = 7, NSRC = 8, REJ_W = 3, SW = 3, DW = 22 + PE_W;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [7:0] cfg_addr = 0;
  logic [DW-1:0] cfg_wdata = 0;
  logic req_valid = 0; logic [15:0] req_rid = 0;
  logic msi_valid = 0; logic [15:0] msi_rid = 0; logic [SW-1:0] msi_src = 0;
  logic cls_valid, cls_hit, msi_accept, msi_reject;
  logic [PE_W-1:0] cls_pe;
  logic [REJ_W-1:0] rej_count;

  always #2 clk = ~clk;

  rid_pe_classifier #(.N(N), .PE_W(PE_W), .NSRC(NSRC), .REJ_W(REJ_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_rid(req_rid),
    .cls_valid(cls_valid), .cls_hit(cls_hit), .cls_pe(cls_pe),
    .msi_valid(msi_valid), .msi_rid(msi_rid), .msi_src(msi_src),
    .msi_accept(msi_accept), .msi_reject(msi_reject), .rej_count(rej_count));

  int vectors = 0, miscompares = 0;
  bit done = 0;
  string phase = "R1";

  // Behavioural reference
  int m_val[N], m_den[N], m_len[N], m_pe[N], m_bus[N], m_fn[N];
  int m_tag[NSRC];
  int e_cv, e_hit, e_pe, e_acc, e_rej, e_cnt;

  function automatic int classify(input int rid, output int pe_o);
    int bus, fn, p;
    bus = (rid >> 8) & 255; fn = rid & 255;
    pe_o = 0;
    for (int i = 0; i < N; i++) begin
      p = (m_len[i] > 8) ? 8 : m_len[i];
      if (m_val[i] != 0 && (bus >> (8 - p)) == (m_bus[i] >> (8 - p)) &&
          (m_den[i] == 0 || fn == m_fn[i])) begin
        pe_o = m_pe[i];
        return 1;
      end
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    int h, p, sh, sp;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_val[i]=0; m_den[i]=0; m_len[i]=0; m_pe[i]=0; m_bus[i]=0; m_fn[i]=0; end
      for (int s = 0; s < NSRC; s++) m_tag[s] = 0;
      e_cv=0; e_hit=0; e_pe=0; e_acc=0; e_rej=0; e_cnt=0;
    end else begin
      h = classify(int'(req_rid), p);
      e_cv = req_valid; e_hit = req_valid && h; e_pe = (req_valid && h) ? p : 0;
      sh = classify(int'(msi_rid), sp);
      e_acc = msi_valid && sh && sp == m_tag[msi_src];
      e_rej = msi_valid && !e_acc;
      if (e_rej && e_cnt < 7) e_cnt++;
      if (cfg_we) begin
        int a; a = int'(cfg_addr);
        if (!cfg_sel && a < N) begin
          m_fn[a] = cfg_wdata[7:0]; m_bus[a] = cfg_wdata[15:8]; m_len[a] = cfg_wdata[19:16];
          m_den[a] = cfg_wdata[20]; m_val[a] = cfg_wdata[21]; m_pe[a] = cfg_wdata[28:22];
        end else if (cfg_sel && a < NSRC) m_tag[a] = cfg_wdata[28:22];
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    vectors++;
    if (cls_valid !== e_cv[0] || cls_hit !== e_hit[0] || cls_pe !== PE_W'(e_pe)) begin
      miscompares++;
      $display("FAIL %s/R6 classify: got v%0b h%0b pe%0d expected v%0d h%0d pe%0d",
               phase, cls_valid, cls_hit, cls_pe, e_cv, e_hit, e_pe);
    end
    if (msi_accept !== e_acc[0] || msi_reject !== e_rej[0]) begin
      miscompares++;
      $display("FAIL %s/R9 R10 msi: got acc%0b rej%0b expected acc%0d rej%0d",
               phase, msi_accept, msi_reject, e_acc, e_rej);
    end
    if (rej_count !== REJ_W'(e_cnt)) begin
      miscompares++;
      $display("FAIL %s/R11 rej_count: got %0d expected %0d", phase, rej_count, e_cnt);
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cfg_we = 0; req_valid = 0; msi_valid = 0;
  endtask

  task automatic put_rule(input int idx, input int v, input int den, input int len,
                          input int pe, input int bus, input int fn);
    @(negedge clk);
    req_valid = 0; msi_valid = 0;
    cfg_we = 1; cfg_sel = 0; cfg_addr = 8'(idx);
    cfg_wdata = {PE_W'(pe), 1'(v), 1'(den), 4'(len), 8'(bus), 8'(fn)};
  endtask

  task automatic put_tag(input int src, input int pe);
    @(negedge clk);
    req_valid = 0; msi_valid = 0;
    cfg_we = 1; cfg_sel = 1; cfg_addr = 8'(src);
    cfg_wdata = {PE_W'(pe), 22'd0};
  endtask

  // Issue one request; result is checked one cycle later
  task automatic lookup(input string tag, input int rid, input int hit, input int pe);
    @(negedge clk);
    cfg_we = 0; msi_valid = 0; req_valid = 1; req_rid = 16'(rid);
    @(negedge clk);
    req_valid = 0;
    check({tag, " hit"}, int'(cls_hit), hit);
    check({tag, " pe"}, int'(cls_pe), pe);
  endtask

  task automatic send_msi(input string tag, input int rid, input int src, input int acc);
    @(negedge clk);
    cfg_we = 0; req_valid = 0; msi_valid = 1; msi_rid = 16'(rid); msi_src = SW'(src);
    @(negedge clk);
    msi_valid = 0;
    check({tag, " accept"}, int'(msi_accept), acc);
    check({tag, " reject"}, int'(msi_reject), 1 - acc);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 cls_valid", int'(cls_valid), 0);
    check("R1 rej_count", int'(rej_count), 0);
    phase = "R8";
    lookup("R8 empty table miss", 16'h1234, 0, 0);
    put_rule(3, 0, 0, 8, 44, 8'h12, 0);             // invalid rule
    lookup("R8 invalid rule ignored", 16'h1234, 0, 0);

    phase = "R2";
    put_rule(2, 1, 0, 4, 5, 8'hA0, 0);
    lookup("R2 prefix 4 match", 16'hA7_19, 1, 5);
    lookup("R2 prefix 4 miss", 16'hB0_19, 0, 0);

    phase = "R3";
    put_rule(15, 1, 0, 0, 9, 8'h00, 0);
    lookup("R3 len 0 any bus", 16'h5E_00, 1, 9);
    put_rule(1, 1, 0, 12, 33, 8'h5E, 0);
    lookup("R3 len>8 exact hit", 16'h5E_44, 1, 33);
    lookup("R3 len>8 near miss", 16'h5F_44, 1, 9);

    phase = "R4";
    put_rule(0, 1, 1, 8, 70, 8'h21, 8'h0A);
    lookup("R4 devfn match", 16'h21_0A, 1, 70);
    lookup("R4 devfn differs", 16'h21_0B, 1, 9);

    phase = "R5";
    lookup("R5 lowest index wins", 16'hA3_00, 1, 5);
    put_rule(2, 0, 0, 0, 0, 0, 0);
    lookup("R5 next rule takes over", 16'hA3_00, 1, 9);

    phase = "R7";
    // write and request in the same cycle: old contents apply
    @(negedge clk);
    cfg_we = 1; cfg_sel = 0; cfg_addr = 8'd4;
    cfg_wdata = {7'd100, 1'b1, 1'b0, 4'd8, 8'h77, 8'h00};
    req_valid = 1; req_rid = 16'h7700;
    @(negedge clk);
    cfg_we = 0; req_valid = 1;
    check("R7 same-cycle sees old", int'(cls_pe), 9);
    @(negedge clk);
    req_valid = 0;
    check("R7 next cycle sees new", int'(cls_pe), 100);
    put_rule(200, 1, 0, 0, 120, 0, 0);              // out of range
    lookup("R12 out-of-range write ignored", 16'h9900, 1, 9);

    phase = "R9";
    put_tag(2, 70);
    put_tag(9, 1);                                   // beyond NSRC: ignored
    send_msi("R9 matching tag accepted", 16'h21_0A, 2, 1);
    phase = "R10";
    send_msi("R10 tag mismatch refused", 16'h21_0B, 2, 0);
    put_rule(15, 0, 0, 0, 0, 0, 0);
    send_msi("R10 unclassified refused", 16'h3300, 0, 0);
    phase = "R11";
    for (int k = 0; k < 8; k++) send_msi("R11 refuse", 16'h3300, 1, 0);
    check("R11 saturated", int'(rej_count), 7);

    phase = "RND";
    for (int c = 0; c < 3000; c++) begin
      int pick;
      @(negedge clk);
      pick = $urandom_range(0, 7);
      cfg_we = (pick == 0);
      cfg_sel = $urandom_range(0, 3) == 0;
      cfg_addr = 8'($urandom_range(0, 18));
      cfg_wdata = DW'({$urandom, $urandom});
      cfg_wdata[15:8] = 8'(8'h40 + $urandom_range(0, 3));
      cfg_wdata[7:0] = 8'($urandom_range(0, 3));
      req_valid = $urandom_range(0, 1);
      req_rid = {8'(8'h40 + $urandom_range(0, 5) * 8'h21), 8'($urandom_range(0, 3))};
      msi_valid = $urandom_range(0, 1);
      msi_rid = {8'(8'h40 + $urandom_range(0, 3)), 8'($urandom_range(0, 3))};
      msi_src = SW'($urandom_range(0, NSRC-1));
    end
    idle(); idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule